// File: doc/BRIEF.md
# Programmable External Bus Timing Controller

This block turns single read and write requests from inside the chip into cycles on a slow parallel bus. It serves five address zones, numbered 0 to 4 at its request port. Every access runs through three phases in a fixed order: a lead phase, an active phase and a trail phase. Each zone has its own programmed length for each phase. Devices with very different speeds can therefore share one bus, from fast static memory to a slow display module. Phase lengths are counted in a bus timing clock. That clock runs either at the system clock rate or at half of it.

A requester presents a request and holds it until the block accepts it. The block accepts a request only while it is idle. It then drives the address, the chip select of the zone and the matching strobe. When the trail phase has ended it returns a one-cycle acknowledge, together with the captured read data. There are three chip-select outputs. Zones 0 and 1 share one, formed by ANDing their active-low selects. Zone 2 has its own. Zones 3 and 4 share the third. A simple register write port programs the zone timings and the timing-clock rate.

Top module: `ebus_timing_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all three chip selects and both strobes are high, and bus_oe and ack are low.
- R2: A configuration write with cfg_sel equal to 0..4 loads that zone's timing. The lead count is in cfg_wdata[2:0], the active count in [6:3] and the trail count in [9:7]. After reset, every zone holds lead 6, active 14 and trail 6.
- R3: A configuration write with cfg_sel equal to 5 sets the timing-clock mode from cfg_wdata[0]. A 1 makes each timing cycle last two system cycles. A 0 makes it last one. Reset selects 1. Writes with cfg_sel 6 or 7 change nothing.
- R4: A request is accepted at the first clock edge at which the block is idle and req_valid is high with req_zone at most 4. For the next L timing cycles (the lead phase), the zone's chip select is low, bus_addr shows the request address, and both strobes are high.
- R5: The active phase lasts A timing cycles. In it, bus_rd_n is low for a read and bus_wr_n is low for a write, and the other strobe stays high.
- R6: The trail phase lasts T timing cycles. In it, both strobes are high, and the chip select and bus_addr keep their values.
- R7: A phase count of 0 lasts one timing cycle. Lead and trail counts above 6 last 6 cycles. Active counts above 14 last 14 cycles.
- R8: For a read, rd_data takes the value of bus_din at the last system cycle of the active phase. It holds that value from the acknowledge until the next read captures new data.
- R9: ack is high for exactly one system cycle, right after the trail phase, while all chip selects are high. A request seen during an access or during the ack cycle is not started until the block is idle. A request with req_zone 5, 6 or 7 causes no bus activity and no ack.
- R10: bus_oe is high only for writes, from the first active cycle to the last trail cycle, and bus_dout then carries the write data.
- R11: Zones 0 and 1 drive bus_cs_a_n, zone 2 drives bus_cs_b_n, and zones 3 and 4 drive bus_cs_c_n. At most one chip-select output is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0..4 zone timing, 5 clock mode |
| cfg_wdata | input | 10 | Configuration write data |
| req_valid | input | 1 | Access request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | 3 | Target zone index |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| bus_cs_a_n | output | 1 | Shared select of zones 0 and 1, active low |
| bus_cs_b_n | output | 1 | Select of zone 2, active low |
| bus_cs_c_n | output | 1 | Shared select of zones 3 and 4, active low |
| bus_addr | output | 20 | Bus address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Read data from the bus |

## Verification
The assertions assume three things. Configuration is not rewritten while an access runs. The requester lowers req_valid once it sees the request taken, and keeps it low until ack, except when it deliberately queues the next request. bus_din may change in any cycle. The stimulus keeps to this. It issues each configuration write only while the block is idle, drops req_valid in the cycle after acceptance, and drives bus_din with random values in every cycle except the last active one. That way, a capture at any other cycle shows up as a mismatch.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
  localparam int NUM_ZONES = 5;
  localparam int ZONE_W    = 3;
  localparam int SEL_W     = 3;
  localparam int LEAD_W    = 3;
  localparam int ACT_W     = 4;
  localparam int TRAIL_W   = 3;
  localparam int CNT_W     = ACT_W;
  localparam int CFG_W     = LEAD_W + ACT_W + TRAIL_W;
  localparam int LEAD_MAX  = 6;
  localparam int ACT_MAX   = 14;
  localparam int TRAIL_MAX = 6;

  typedef struct packed {
    logic [TRAIL_W-1:0] trail;
    logic [ACT_W-1:0]   act;
    logic [LEAD_W-1:0]  lead;
  } zone_tim_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_ACT, PH_TRAIL, PH_ACK
  } phase_e;

  // Effective phase length: zero means one cycle, large values are capped.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] mx);
    if (v == '0) return CNT_W'(1);
    if (v > mx) return mx;
    return v;
  endfunction
endpackage

// File: rtl/ebus_cfg_regs.sv
`timescale 1ns/1ps
module ebus_cfg_regs
  import ebus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output zone_tim_t        tim_o [NUM_ZONES],
  output logic             half_rate_o
);
  localparam zone_tim_t TIM_RST = '{trail: TRAIL_W'(TRAIL_MAX),
                                    act:   ACT_W'(ACT_MAX),
                                    lead:  LEAD_W'(LEAD_MAX)};
  localparam logic [SEL_W-1:0] CLK_SEL = SEL_W'(NUM_ZONES);

  for (genvar zi = 0; zi < NUM_ZONES; zi++) begin : g_zone
    always_ff @(posedge clk) begin
      if (rst)
        tim_o[zi] <= TIM_RST;
      else if (cfg_we && cfg_sel == SEL_W'(zi))
        tim_o[zi] <= zone_tim_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      half_rate_o <= 1'b1;
    else if (cfg_we && cfg_sel == CLK_SEL)
      half_rate_o <= cfg_wdata[0];
  end

  // R3: the rate bit only moves on a write to its own select
  assert_rate_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == CLK_SEL) |=> $stable(half_rate_o));
endmodule

// File: rtl/ebus_tick_gen.sv
`timescale 1ns/1ps
module ebus_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic half_rate,
  output logic tick_last
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst || restart)
      tog <= 1'b0;
    else if (half_rate)
      tog <= ~tog;
    else
      tog <= 1'b0;
  end

  assign tick_last = !half_rate || tog;

  // R3: at half rate a timing-cycle end is followed by a non-end cycle
  assert_half_alt_R3: assert property (@(posedge clk) disable iff (rst)
    (half_rate && !restart && tick_last) |=> !tick_last);
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ZONE_W-1:0]     req_zone,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  zone_tim_t             tim_i [NUM_ZONES],
  input  logic                  half_cfg,
  input  logic                  tick_last,
  input  logic [DATA_W-1:0]     bus_din,
  output logic                  restart,
  output logic                  half_lat,
  output logic [NUM_ZONES-1:0]  cs_n,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic                  oe,
  output logic [DATA_W-1:0]     dout,
  output logic                  ack,
  output logic [DATA_W-1:0]     rd_data
);
  localparam logic [CNT_W-1:0] LEAD_CAP  = CNT_W'(LEAD_MAX);
  localparam logic [CNT_W-1:0] ACT_CAP   = CNT_W'(ACT_MAX);
  localparam logic [CNT_W-1:0] TRAIL_CAP = CNT_W'(TRAIL_MAX);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  phase_e             phase, nph;
  logic [CNT_W-1:0]   cnt, ncnt;
  zone_tim_t          tim_lat;
  logic [ZONE_W-1:0]  zone_lat, zone_nx;
  logic               wr_lat, wr_nx, accept, busy_nx, zone_ok;

  assign zone_ok = req_zone < ZONE_W'(NUM_ZONES);

  always_comb begin
    nph    = phase;
    ncnt   = cnt;
    accept = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid && zone_ok) begin
        accept = 1'b1;
        nph    = PH_LEAD;
        ncnt   = eff_len(CNT_W'(tim_i[req_zone].lead), LEAD_CAP) - ONE;
      end
      PH_LEAD: if (tick_last) begin
        if (cnt == '0) begin
          nph  = PH_ACT;
          ncnt = eff_len(CNT_W'(tim_lat.act), ACT_CAP) - ONE;
        end else ncnt = cnt - ONE;
      end
      PH_ACT: if (tick_last) begin
        if (cnt == '0) begin
          nph  = PH_TRAIL;
          ncnt = eff_len(CNT_W'(tim_lat.trail), TRAIL_CAP) - ONE;
        end else ncnt = cnt - ONE;
      end
      PH_TRAIL: if (tick_last) begin
        if (cnt == '0) nph = PH_ACK;
        else ncnt = cnt - ONE;
      end
      PH_ACK:  nph = PH_IDLE;
      default: nph = PH_IDLE;
    endcase
  end

  assign restart = accept;
  assign zone_nx = accept ? req_zone  : zone_lat;
  assign wr_nx   = accept ? req_write : wr_lat;
  assign busy_nx = (nph == PH_LEAD) || (nph == PH_ACT) || (nph == PH_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tim_lat  <= '0;
      zone_lat <= '0;
      wr_lat   <= 1'b0;
      half_lat <= 1'b1;
      cs_n     <= '1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      oe       <= 1'b0;
      ack      <= 1'b0;
      bus_addr <= '0;
      dout     <= '0;
      rd_data  <= '0;
    end else begin
      phase <= nph;
      cnt   <= ncnt;
      if (accept) begin
        tim_lat  <= tim_i[req_zone];
        zone_lat <= req_zone;
        wr_lat   <= req_write;
        half_lat <= half_cfg;
        bus_addr <= req_addr;
        dout     <= req_wdata;
      end
      for (int z = 0; z < NUM_ZONES; z++)
        cs_n[z] <= !(busy_nx && zone_nx == ZONE_W'(z));
      rd_n <= !(nph == PH_ACT && !wr_nx);
      wr_n <= !(nph == PH_ACT && wr_nx);
      oe   <= ((nph == PH_ACT) || (nph == PH_TRAIL)) && wr_nx;
      ack  <= (nph == PH_ACK);
      if (phase == PH_ACT && tick_last && cnt == '0 && !wr_lat)
        rd_data <= bus_din;
    end
  end

  // R5: the two strobes are never low together
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R4: a strobe is only low inside a selected zone
  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> (cs_n != '1));
  // R10: the data driver never overlaps a read strobe
  assert_oe_no_read_R10: assert property (@(posedge clk) disable iff (rst)
    oe |-> rd_n);
  // R9: acknowledge lasts one cycle and comes with the bus released
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cs_n == '1 && rd_n && wr_n && !oe));
  // R6: address holds while a select stays low
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((cs_n != '1) && $past(cs_n != '1)) |-> $stable(bus_addr));
endmodule

// File: rtl/ebus_timing_ctrl.sv
`timescale 1ns/1ps
module ebus_timing_ctrl
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ZONE_W-1:0] req_zone,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_cs_a_n,
  output logic              bus_cs_b_n,
  output logic              bus_cs_c_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);
  zone_tim_t              tim [NUM_ZONES];
  logic                   half_cfg, half_lat, restart, tick_last;
  logic [NUM_ZONES-1:0]   cs_n;

  ebus_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tim_o(tim), .half_rate_o(half_cfg)
  );

  ebus_tick_gen u_tick (
    .clk(clk), .rst(rst), .restart(restart), .half_rate(half_lat),
    .tick_last(tick_last)
  );

  ebus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_zone(req_zone), .req_addr(req_addr), .req_wdata(req_wdata),
    .tim_i(tim), .half_cfg(half_cfg), .tick_last(tick_last),
    .bus_din(bus_din), .restart(restart), .half_lat(half_lat),
    .cs_n(cs_n), .bus_addr(bus_addr), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .oe(bus_oe), .dout(bus_dout), .ack(ack), .rd_data(rd_data)
  );

  // Paired zones share one select: low when either member is low.
  assign bus_cs_a_n = cs_n[0] & cs_n[1];
  assign bus_cs_b_n = cs_n[2];
  assign bus_cs_c_n = cs_n[3] & cs_n[4];

  // R11: never more than one select output low
  assert_one_group_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({~bus_cs_a_n, ~bus_cs_b_n, ~bus_cs_c_n}) <= 1);
endmodule

// File: tb/tb_ebus_timing_ctrl.sv
`timescale 1ns/1ps
module tb_ebus_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [9:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_zone = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic        ack, bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, bus_rd_n, bus_wr_n, bus_oe;
  logic [15:0] rd_data, bus_dout;
  logic [19:0] bus_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int ml [5], ma [5], mt [5];
  bit mh;

  always #2 clk = ~clk;

  ebus_timing_ctrl dut (.*);

  function automatic int eff(input int v, input int mx);
    if (v == 0) return 1;
    if (v > mx) return mx;
    return v;
  endfunction

  function automatic logic [2:0] exp_cs(input int z, input bit busy);
    logic [2:0] r = 3'b111;
    if (busy) begin
      if (z <= 1) r[2] = 1'b0;
      else if (z == 2) r[1] = 1'b0;
      else r[0] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input int sel, input logic [9:0] d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 5) begin ml[sel] = d[2:0]; ma[sel] = d[6:3]; mt[sel] = d[9:7]; end
    else if (sel == 5) mh = d[0];
  endtask

  // Called at a negedge with the block idle; returns at a negedge with it idle.
  task automatic run_access(input bit w, input int z, input logic [19:0] a,
                            input logic [15:0] wd, input logic [15:0] rv,
                            input bit queue_next);
    int L = eff(ml[z], 6), A = eff(ma[z], 14), T = eff(mt[z], 6);
    int D = mh ? 2 : 1;
    req_valid = 1'b1; req_write = w; req_zone = 3'(z);
    req_addr = a; req_wdata = wd; bus_din = 16'($urandom);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 20'($urandom); req_wdata = 16'($urandom);
    for (int k = 0; k < (L + A + T) * D; k++) begin
      bit in_act = (k >= L * D) && (k < (L + A) * D);
      bit in_tr  = (k >= (L + A) * D);
      string tag = in_act ? "R5" : (in_tr ? "R6" : "R4");
      logic [5:0] ev = {exp_cs(z, 1'b1), !(in_act && !w), !(in_act && w),
                        (in_act || in_tr) && w};
      bus_din = (k == (L + A) * D - 1) ? rv : 16'($urandom);
      chk({tag, "/R11 strobes"}, 32'({bus_cs_a_n, bus_cs_b_n, bus_cs_c_n,
          bus_rd_n, bus_wr_n, bus_oe}), 32'(ev));
      chk({tag, " addr"}, 32'(bus_addr), 32'(a));
      if (ev[0]) chk("R10 dout", 32'(bus_dout), 32'(wd));
      @(negedge clk);
    end
    chk("R9 ack", 32'({ack, bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, bus_oe}), 32'(5'b11110));
    if (!w) chk("R8 rd_data", 32'(rd_data), 32'(rv));
    if (queue_next) begin
      req_valid = 1'b1; req_write = 1'b0; req_zone = 3'd2; req_addr = 20'h2222;
    end
    @(negedge clk);
    chk("R9 ack end", 32'({ack, bus_cs_a_n, bus_cs_b_n, bus_cs_c_n}), 32'(4'b0111));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 5; i++) begin ml[i] = 6; ma[i] = 14; mt[i] = 6; end
    mh = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 reset", 32'({bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, bus_rd_n, bus_wr_n,
        bus_oe, ack}), 32'(7'b1111100));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", 32'({bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, bus_rd_n, bus_wr_n,
        bus_oe, ack}), 32'(7'b1111100));
    // R2/R3: reset timings 6/14/6 at half rate
    run_access(1'b0, 0, 20'h0_1234, 16'h0, 16'hA5A5, 1'b0);
    run_access(1'b1, 3, 20'hF_0F0F, 16'hBEEF, 16'h0, 1'b0);
    // R3: full rate; writes to select 6 have no effect
    cfg_write(5, 10'd0);
    cfg_write(6, 10'h3FF);
    cfg_write(2, {3'd1, 4'd1, 3'd1});
    run_access(1'b1, 2, 20'h0_0002, 16'h1357, 16'h0, 1'b0);
    run_access(1'b0, 2, 20'h0_0003, 16'h0, 16'h2468, 1'b0);
    // R7: zero counts last one cycle
    cfg_write(3, 10'd0);
    run_access(1'b0, 3, 20'h3_3333, 16'h0, 16'h0F0F, 1'b0);
    // R7: oversize counts are capped
    cfg_write(4, 10'h3FF);
    run_access(1'b1, 4, 20'h4_4444, 16'hCAFE, 16'h0, 1'b0);
    cfg_write(5, 10'd1);
    run_access(1'b0, 4, 20'h4_0004, 16'h0, 16'h7777, 1'b0);
    // R11: zone 1 shares the first select
    cfg_write(1, {3'd2, 4'd3, 3'd4});
    run_access(1'b0, 1, 20'h1_1111, 16'h0, 16'h9999, 1'b0);
    // R9: request raised in the ack cycle waits for idle
    run_access(1'b1, 1, 20'h1_0001, 16'h4321, 16'h0, 1'b1);
    chk("R9 queued idle", 32'({bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, ack}), 32'(4'b1110));
    run_access(1'b0, 2, 20'h2222, 16'h0, 16'h5151, 1'b0);
    // R9: zone indexes 5..7 are ignored
    for (int zz = 5; zz < 8; zz++) begin
      req_valid = 1'b1; req_zone = 3'(zz); req_write = 1'b1;
      repeat (2) begin
        @(negedge clk);
        chk("R9 bad zone", 32'({bus_cs_a_n, bus_cs_b_n, bus_cs_c_n, bus_wr_n,
            bus_oe, ack}), 32'(6'b111100));
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    // Random mix
    for (int n = 0; n < 150; n++) begin
      if ($urandom % 4 == 0) cfg_write(int'($urandom % 5), 10'($urandom));
      if ($urandom % 8 == 0) cfg_write(5, 10'($urandom % 2));
      run_access(1'($urandom), int'($urandom % 5), 20'($urandom), 16'($urandom),
                 16'($urandom), 1'b0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule